// File: doc/BRIEF.md
# Policy-Selectable Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a word-wide memory bus. Each processor request brings its own write-policy attribute. A write-through write updates a line that hits and is always sent to memory. A write-back write that hits changes only the cached line and marks it dirty. Lines are allocated only on read misses. Before a fill replaces a dirty line, the dirty line is written back to memory. A flush command writes every dirty line back to memory and leaves the lines valid and clean.

Two controls are meant for a debugger. A fill-inhibit level stops lines from being loaded or replaced, so the cache contents are frozen while memory is inspected. Hits are still served from the cache, and misses go straight to memory as single-word transfers. An invalidate command takes a line address and drops the matching line, dirty or not, so the next access to that line refetches it from memory. All memory traffic uses one-word transfers, and line transfers are four beats in ascending word order.

Top module: `pol_dcache`

## Requirements
- R1: A write with `cpu_wb`=0 (write-through) produces exactly one memory word write to `cpu_addr`. If the line hits, the cached word is also updated, so a later read returns the new value.
- R2: A write with `cpu_wb`=1 (write-back) that hits updates the cached word and marks the line dirty, with no memory transfer during that access.
- R3: A read miss with `fill_inhibit`=0 allocates the line. If the line currently held at that index is valid and dirty, its four words are first written to memory. Then the four words of the new line are read, and the requested word is returned. A read hit causes no memory transfer.
- R4: While `flush_req` is held, the block writes back every valid dirty line, four words each, scanning indices from 0 upward. Each such line stays valid and becomes clean. `flush_done` then pulses high for exactly one cycle.
- R5: A write miss, under either policy, performs one memory word write and does not allocate, so a following read of that address misses.
- R6: While `fill_inhibit`=1, a read miss is served by exactly one memory word read from `cpu_addr` and leaves the cache unchanged, while read hits are still answered from the cache with no memory transfer.
- R7: `inv_req` is accepted only while the block is idle, with `inv_ack` high in that same cycle. `inv_addr` is a line address (word address without its two offset bits). A matching line is made invalid and its dirty data is discarded, not written back.
- R8: Word address fields: bits [1:0] select the word in the line, bits [5:2] the line index, and the upper bits form the tag. `mem_req`, `mem_addr` and `mem_we` stay unchanged until `mem_ack`, and one word moves per acknowledged cycle. Line transfers use offsets 0,1,2,3 in order.
- R9: After reset all lines are invalid, and `cpu_ack`, `mem_req`, `flush_done` and `inv_ack` are low while no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wb | input | 1 | Write policy of this access: 1 = write-back, 0 = write-through |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ack` is high |
| fill_inhibit | input | 1 | Debug: no line loads or replacements |
| flush_req | input | 1 | Flush command, held until `flush_done` |
| flush_done | output | 1 | One-cycle flush completion pulse |
| inv_req | input | 1 | Invalidate command |
| inv_addr | input | ADDR_W-2 | Line address to invalidate |
| inv_ack | output | 1 | Invalidate accepted this cycle |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transfer complete this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the cache with its default parameters: 16 lines of 4 words, a 10-bit word address and 32-bit data. That leaves a 4-bit tag. Random addresses are limited to four tag values, so index conflicts, dirty evictions and hits under both policies happen often. A full flush scan takes only a few dozen cycles, which allows flushes to be mixed into the random stream. The memory model adds random wait states, which exercises the rule that the request is held steady. After every flush the whole 1024-word memory is compared against a predicted image.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RESP,
    ST_MEMWR,
    ST_MEMRD,
    ST_WBACK,
    ST_FILL,
    ST_FSCAN,
    ST_FDONE
  } pdc_state_t;

endpackage

// File: rtl/pdc_tags.sv
module pdc_tags #(
  parameter int LINES = 16,
  parameter int TAG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  output logic                     rd_valid,
  output logic                     rd_dirty,
  output logic [TAG_W-1:0]         rd_tag,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic                     set_line,
  input  logic                     set_dirty,
  input  logic                     clr_dirty,
  input  logic                     clr_valid
);

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (set_line) begin
      valid_d[wr_idx] = 1'b1;
      dirty_d[wr_idx] = 1'b0;
    end
    if (set_dirty) dirty_d[wr_idx] = 1'b1;
    if (clr_dirty) dirty_d[wr_idx] = 1'b0;
    if (clr_valid) begin
      valid_d[wr_idx] = 1'b0;
      dirty_d[wr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  // tag storage: no reset, qualified by valid
  always_ff @(posedge clk) begin
    if (set_line) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // a fill never lands on a line still holding unsaved data
  assert_fill_over_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_line |-> !(valid_q[wr_idx] && dirty_q[wr_idx]));

  // a completed flush write-back leaves the line clean and valid
  assert_clean_after_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_dirty && !clr_valid && valid_q[wr_idx]) |=> (!dirty_q[$past(wr_idx)] && valid_q[$past(wr_idx)]));

endmodule

// File: rtl/pdc_data.sv
module pdc_data #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [$clog2(WORDS)-1:0] wr_off,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  input  logic [$clog2(WORDS)-1:0] rd_off,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int DEPTH = LINES * WORDS;

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) word_q[{wr_idx, wr_off}] <= wr_data;
  end

  assign rd_data = word_q[{rd_idx, rd_off}];

  // compile-time shape check
  initial begin
    assert (IDX_W + OFF_W == $clog2(DEPTH)) else $error("line geometry must be powers of two");
  end

endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic                     cpu_wb,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic                     cpu_ack,
  output logic [DATA_W-1:0]        cpu_rdata,
  input  logic                     fill_inhibit,
  input  logic                     flush_req,
  output logic                     flush_done,
  input  logic                     inv_req,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] inv_addr,
  output logic                     inv_ack,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic                     mem_ack,
  input  logic [DATA_W-1:0]        mem_rdata,
  // tag array
  output logic [$clog2(LINES)-1:0] t_rd_idx,
  input  logic                     t_rd_valid,
  input  logic                     t_rd_dirty,
  input  logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] t_rd_tag,
  output logic [$clog2(LINES)-1:0] t_wr_idx,
  output logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] t_wr_tag,
  output logic                     t_set_line,
  output logic                     t_set_dirty,
  output logic                     t_clr_dirty,
  output logic                     t_clr_valid,
  // data array
  output logic [$clog2(LINES)-1:0] d_rd_idx,
  output logic [$clog2(WORDS)-1:0] d_rd_off,
  input  logic [DATA_W-1:0]        d_rd_data,
  output logic                     d_we,
  output logic [$clog2(LINES)-1:0] d_wr_idx,
  output logic [$clog2(WORDS)-1:0] d_wr_off,
  output logic [DATA_W-1:0]        d_wr_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(LINES - 1);

  pdc_state_t        state_q, state_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              req_we_q, req_wb_q;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic [IDX_W-1:0]  fl_idx_q, fl_idx_d;
  logic              flushing_q, flushing_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_load;
  logic              accept;

  logic [TAG_W-1:0]  req_tag, inv_tag;
  logic [IDX_W-1:0]  req_idx, inv_idx, cur_idx;
  logic [OFF_W-1:0]  req_off;
  logic              hit, inv_hit, fl_last;

  assign req_tag = req_addr_q[ADDR_W-1 -: TAG_W];
  assign req_idx = req_addr_q[OFF_W +: IDX_W];
  assign req_off = req_addr_q[OFF_W-1:0];
  assign inv_tag = inv_addr[IDX_W +: TAG_W];
  assign inv_idx = inv_addr[IDX_W-1:0];
  assign cur_idx = flushing_q ? fl_idx_q : req_idx;
  assign fl_last = (fl_idx_q == LAST_LINE);

  assign t_rd_idx = (state_q == ST_IDLE) ? inv_idx : cur_idx;
  assign t_wr_idx = (state_q == ST_IDLE) ? inv_idx : cur_idx;
  assign t_wr_tag = req_tag;
  assign hit      = t_rd_valid && (t_rd_tag == req_tag);
  assign inv_hit  = t_rd_valid && (t_rd_tag == inv_tag);

  assign d_rd_idx = cur_idx;
  assign d_rd_off = (state_q == ST_WBACK) ? beat_q : req_off;

  assign cpu_ack   = (state_q == ST_RESP);
  assign cpu_rdata = rdata_q;
  assign flush_done = (state_q == ST_FDONE);

  // memory side: one word per acknowledged cycle
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_addr_q;
    mem_wdata = req_wdata_q;
    unique case (state_q)
      ST_MEMWR: begin mem_req = 1'b1; mem_we = 1'b1; end
      ST_MEMRD: mem_req = 1'b1;
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {t_rd_tag, cur_idx, beat_q};
        mem_wdata = d_rd_data;
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {req_tag, req_idx, beat_q};
      end
      default: ;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    fl_idx_d    = fl_idx_q;
    flushing_d  = flushing_q;
    rdata_d     = rdata_q;
    rdata_load  = 1'b0;
    accept      = 1'b0;
    inv_ack     = 1'b0;
    t_set_line  = 1'b0;
    t_set_dirty = 1'b0;
    t_clr_dirty = 1'b0;
    t_clr_valid = 1'b0;
    d_we        = 1'b0;
    d_wr_idx    = req_idx;
    d_wr_off    = req_off;
    d_wr_data   = req_wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (inv_req) begin
          inv_ack     = 1'b1;
          t_clr_valid = inv_hit;
        end else if (flush_req) begin
          flushing_d = 1'b1;
          fl_idx_d   = '0;
          state_d    = ST_FSCAN;
        end else if (cpu_req) begin
          accept  = 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        beat_d = '0;
        if (req_we_q) begin
          d_we = hit;
          if (hit && req_wb_q) begin
            t_set_dirty = 1'b1;
            state_d     = ST_RESP;
          end else begin
            state_d = ST_MEMWR;
          end
        end else if (hit) begin
          rdata_d    = d_rd_data;
          rdata_load = 1'b1;
          state_d    = ST_RESP;
        end else if (fill_inhibit) begin
          state_d = ST_MEMRD;
        end else if (t_rd_valid && t_rd_dirty) begin
          state_d = ST_WBACK;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_MEMWR: if (mem_ack) state_d = ST_RESP;
      ST_MEMRD: begin
        if (mem_ack) begin
          rdata_d    = mem_rdata;
          rdata_load = 1'b1;
          state_d    = ST_RESP;
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          beat_d = beat_q + OFF_W'(1);
          if (beat_q == LAST_BEAT) begin
            t_clr_dirty = 1'b1;
            if (!flushing_q)   state_d = ST_FILL;
            else if (fl_last)  state_d = ST_FDONE;
            else begin
              fl_idx_d = fl_idx_q + IDX_W'(1);
              state_d  = ST_FSCAN;
            end
          end
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          d_we      = 1'b1;
          d_wr_off  = beat_q;
          d_wr_data = mem_rdata;
          beat_d    = beat_q + OFF_W'(1);
          if (beat_q == req_off) begin
            rdata_d    = mem_rdata;
            rdata_load = 1'b1;
          end
          if (beat_q == LAST_BEAT) begin
            t_set_line = 1'b1;
            state_d    = ST_RESP;
          end
        end
      end
      ST_FSCAN: begin
        beat_d = '0;
        if (t_rd_valid && t_rd_dirty) state_d = ST_WBACK;
        else if (fl_last)             state_d = ST_FDONE;
        else                          fl_idx_d = fl_idx_q + IDX_W'(1);
      end
      ST_FDONE: begin
        flushing_d = 1'b0;
        state_d    = ST_IDLE;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      beat_q     <= '0;
      fl_idx_q   <= '0;
      flushing_q <= 1'b0;
      req_we_q   <= 1'b0;
      req_wb_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      beat_q     <= beat_d;
      fl_idx_q   <= fl_idx_d;
      flushing_q <= flushing_d;
      if (accept) begin
        req_we_q <= cpu_we;
        req_wb_q <= cpu_wb;
      end
    end
  end

  // datapath registers: enables only, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      req_addr_q  <= cpu_addr;
      req_wdata_q <= cpu_wdata;
    end
    if (rdata_load) rdata_q <= rdata_d;
  end

  // ---------------- observation state for assertions ----------------
  logic saw_mwr_q, saw_any_q, saw_fill_q, req_hit_q, req_inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saw_mwr_q  <= 1'b0;
      saw_any_q  <= 1'b0;
      saw_fill_q <= 1'b0;
      req_hit_q  <= 1'b0;
      req_inh_q  <= 1'b0;
    end else if (accept) begin
      saw_mwr_q  <= 1'b0;
      saw_any_q  <= 1'b0;
      saw_fill_q <= 1'b0;
      req_hit_q  <= 1'b0;
      req_inh_q  <= 1'b0;
    end else begin
      if (mem_req && mem_ack && mem_we) saw_mwr_q <= 1'b1;
      if (mem_req && mem_ack)           saw_any_q <= 1'b1;
      if (t_set_line)                   saw_fill_q <= 1'b1;
      if (state_q == ST_LOOK) begin
        req_hit_q <= hit;
        req_inh_q <= !req_we_q && !hit && fill_inhibit;
      end
    end
  end

  assert_wt_reaches_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && req_we_q && !req_wb_q) |-> saw_mwr_q);

  assert_wb_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && req_we_q && req_wb_q && req_hit_q) |-> !saw_any_q);

  assert_write_miss_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && req_we_q && !req_hit_q) |-> (saw_mwr_q && !saw_fill_q));

  assert_inhibit_no_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && req_inh_q) |-> !saw_fill_q);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: rtl/pol_dcache.sv
module pol_dcache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic                      cpu_wb,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic                      cpu_ack,
  output logic [DATA_W-1:0]         cpu_rdata,
  input  logic                      fill_inhibit,
  input  logic                      flush_req,
  output logic                      flush_done,
  input  logic                      inv_req,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] inv_addr,
  output logic                      inv_ack,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic                      mem_ack,
  input  logic [DATA_W-1:0]         mem_rdata
);

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]  t_rd_idx, t_wr_idx, d_rd_idx, d_wr_idx;
  logic              t_rd_valid, t_rd_dirty;
  logic [TAG_W-1:0]  t_rd_tag, t_wr_tag;
  logic              t_set_line, t_set_dirty, t_clr_dirty, t_clr_valid;
  logic [OFF_W-1:0]  d_rd_off, d_wr_off;
  logic [DATA_W-1:0] d_rd_data, d_wr_data;
  logic              d_we;

  pdc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wb(cpu_wb),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .fill_inhibit(fill_inhibit),
    .flush_req(flush_req), .flush_done(flush_done),
    .inv_req(inv_req), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .t_rd_idx(t_rd_idx), .t_rd_valid(t_rd_valid), .t_rd_dirty(t_rd_dirty),
    .t_rd_tag(t_rd_tag), .t_wr_idx(t_wr_idx), .t_wr_tag(t_wr_tag),
    .t_set_line(t_set_line), .t_set_dirty(t_set_dirty),
    .t_clr_dirty(t_clr_dirty), .t_clr_valid(t_clr_valid),
    .d_rd_idx(d_rd_idx), .d_rd_off(d_rd_off), .d_rd_data(d_rd_data),
    .d_we(d_we), .d_wr_idx(d_wr_idx), .d_wr_off(d_wr_off), .d_wr_data(d_wr_data)
  );

  pdc_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(t_rd_idx), .rd_valid(t_rd_valid), .rd_dirty(t_rd_dirty), .rd_tag(t_rd_tag),
    .wr_idx(t_wr_idx), .wr_tag(t_wr_tag),
    .set_line(t_set_line), .set_dirty(t_set_dirty),
    .clr_dirty(t_clr_dirty), .clr_valid(t_clr_valid)
  );

  pdc_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(d_we),
    .wr_idx(d_wr_idx), .wr_off(d_wr_off), .wr_data(d_wr_data),
    .rd_idx(d_rd_idx), .rd_off(d_rd_off), .rd_data(d_rd_data)
  );

  // reset state of the command outputs
  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!cpu_ack && !mem_req && !flush_done));

endmodule

// File: tb/pol_dcache_test.sv
module pol_dcache_test;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NL = 16;
  localparam int NW = 4;
  localparam int OW = 2;
  localparam int IW = 4;
  localparam int TW = AW - IW - OW;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we, cpu_wb;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic fill_inhibit, flush_req, flush_done, inv_req, inv_ack;
  logic [AW-OW-1:0] inv_addr;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;  // 250 MHz

  pol_dcache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wb(cpu_wb), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .fill_inhibit(fill_inhibit), .flush_req(flush_req), .flush_done(flush_done),
    .inv_req(inv_req), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [DW-1:0] init_val(input int a);
    return 32'h5A00_0000 | (a * 32'h0001_0003);
  endfunction

  // ---------------- memory responder (sole owner of its state) ----------------
  logic [DW-1:0] mem [MSZ];
  bit            mem_vld [MSZ];
  int            wr_cnt = 0;
  int            rd_cnt = 0;
  logic [AW-1:0] rd_log [4];
  int            dly = 0;

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
  end

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req === 1'b1) begin
      if (dly > 0) dly--;
      else begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          mem_vld[mem_addr] = 1'b1;
          wr_cnt++;
        end else begin
          mem_rdata = mem_vld[mem_addr] ? mem[mem_addr] : init_val(int'(mem_addr));
          rd_log[rd_cnt & 3] = mem_addr;
          rd_cnt++;
        end
        dly = $urandom % 3;
      end
    end
  end

  // ---------------- reference model ----------------
  bit            m_valid [NL];
  bit            m_dirty [NL];
  logic [TW-1:0] m_tag [NL];
  logic [DW-1:0] m_data [NL][NW];
  logic [DW-1:0] exp_mem [MSZ];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input bit wb, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd);
    int idx = int'(a[OW +: IW]);
    int off = int'(a[OW-1:0]);
    logic [TW-1:0] t = a[AW-1 -: TW];
    bit hit = m_valid[idx] && (m_tag[idx] == t);
    int ew = 0, er = 0, bw, br;
    bit alloc = 1'b0;
    string req;
    logic [DW-1:0] ed = '0, got;
    if (we) begin
      if (hit) m_data[idx][off] = wd;
      if (hit && wb) begin
        m_dirty[idx] = 1'b1; req = "R2";
      end else begin
        exp_mem[a] = wd; ew = 1; req = hit ? "R1" : "R5";
      end
    end else if (hit) begin
      ed = m_data[idx][off]; req = fill_inhibit ? "R6" : "R3";
    end else if (fill_inhibit) begin
      ed = exp_mem[a]; er = 1; req = "R6";
    end else begin
      if (m_dirty[idx]) begin
        for (int k = 0; k < NW; k++) exp_mem[{m_tag[idx], idx[IW-1:0], k[OW-1:0]}] = m_data[idx][k];
        ew = NW;
      end
      for (int k = 0; k < NW; k++) m_data[idx][k] = exp_mem[{t, idx[IW-1:0], k[OW-1:0]}];
      m_valid[idx] = 1'b1; m_tag[idx] = t; m_dirty[idx] = 1'b0;
      er = NW; alloc = 1'b1; ed = m_data[idx][off]; req = "R3";
    end
    @(negedge clk);
    bw = wr_cnt; br = rd_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_wb = wb; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    while (cpu_ack !== 1'b1) @(negedge clk);
    got = cpu_rdata;
    cpu_req = 1'b0;
    if (!we) check(got == ed, req, "read data", got, ed);
    check((wr_cnt - bw) == ew && (rd_cnt - br) == er, req, "memory writes*256+reads",
          DW'((wr_cnt - bw) * 256 + (rd_cnt - br)), DW'(ew * 256 + er));
    if (alloc) begin
      bit ord = 1'b1;
      for (int k = 0; k < NW; k++)
        if (rd_log[(br + k) & 3] != {t, idx[IW-1:0], k[OW-1:0]}) ord = 1'b0;
      check(ord, "R8", "fill beat addresses in order", DW'(rd_log[br & 3]), DW'({t, idx[IW-1:0], 2'b00}));
    end
  endtask

  task automatic mem_image_check(input string req);
    int bad = 0;
    logic [DW-1:0] act;
    for (int a = 0; a < MSZ; a++) begin
      act = mem_vld[a] ? mem[a] : init_val(a);
      if (act != exp_mem[a]) bad++;
    end
    check(bad == 0, req, "memory image mismatching words", DW'(bad), 0);
  endtask

  task automatic flush();
    int ew = 0, bw, cyc = 0, pulses = 0;
    for (int i = 0; i < NL; i++)
      if (m_valid[i] && m_dirty[i]) begin
        for (int k = 0; k < NW; k++) exp_mem[{m_tag[i], i[IW-1:0], k[OW-1:0]}] = m_data[i][k];
        m_dirty[i] = 1'b0;
        ew += NW;
      end
    @(negedge clk);
    bw = wr_cnt;
    flush_req = 1'b1;
    @(negedge clk);
    while (flush_done !== 1'b1) @(negedge clk);
    flush_req = 1'b0;
    check((wr_cnt - bw) == ew, "R4", "flush write beats", DW'(wr_cnt - bw), DW'(ew));
    // done must be a single pulse
    @(negedge clk);
    check(flush_done == 1'b0, "R4", "flush_done width", DW'(flush_done), 0);
    mem_image_check("R4");
    cyc = cyc + pulses;
  endtask

  task automatic invalidate(input logic [AW-1:0] a);
    int idx = int'(a[OW +: IW]);
    @(negedge clk);
    inv_req = 1'b1; inv_addr = a[AW-1:OW];
    #1;
    check(inv_ack == 1'b1, "R7", "inv_ack in request cycle", DW'(inv_ack), 1);
    @(negedge clk);
    inv_req = 1'b0;
    if (m_valid[idx] && m_tag[idx] == a[AW-1 -: TW]) begin
      m_valid[idx] = 1'b0; m_dirty[idx] = 1'b0;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
    return {t[TW-1:0], i[IW-1:0], o[OW-1:0]};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < MSZ; a++) exp_mem[a] = init_val(a);
    for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_wb = 0; cpu_addr = '0; cpu_wdata = '0;
    fill_inhibit = 0; flush_req = 0; inv_req = 0; inv_addr = '0;
    repeat (4) @(negedge clk);
    check(cpu_ack == 0 && mem_req == 0 && flush_done == 0, "R9", "outputs in reset",
          DW'({cpu_ack, mem_req, flush_done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cpu_ack == 0 && mem_req == 0 && flush_done == 0 && inv_ack == 0, "R9", "outputs after reset",
          DW'({cpu_ack, mem_req, flush_done, inv_ack}), 0);

    // directed corner cases
    access(0, 0, mk(1, 3, 2), '0);             // R9/R3 cold miss, clean fill
    access(0, 0, mk(1, 3, 0), '0);             // R3 hit
    access(1, 1, mk(1, 3, 1), 32'hDEAD_0001);  // R2 write-back hit
    access(0, 0, mk(1, 3, 1), '0);             // R2 readback
    access(1, 0, mk(1, 3, 3), 32'hBEEF_0003);  // R1 write-through hit
    access(0, 0, mk(1, 3, 3), '0);             // R1 readback from cache
    access(1, 1, mk(2, 5, 0), 32'h1234_5678);  // R5 write-back miss
    access(1, 0, mk(3, 5, 1), 32'h8765_4321);  // R5 write-through miss
    access(0, 0, mk(2, 5, 0), '0);             // R5 no allocation: misses now
    access(0, 0, mk(2, 3, 2), '0);             // R3 dirty victim written back
    access(1, 1, mk(2, 3, 2), 32'hCAFE_F00D);  // make line dirty again
    fill_inhibit = 1'b1;
    access(0, 0, mk(0, 3, 1), '0);             // R6 miss under inhibit
    access(0, 0, mk(0, 3, 1), '0);             // R6 still not allocated
    access(0, 0, mk(2, 3, 2), '0);             // R6 hit under inhibit
    fill_inhibit = 1'b0;
    invalidate(mk(2, 3, 0));                   // R7 dirty line dropped
    access(0, 0, mk(2, 3, 2), '0);             // R7 refetched from memory
    invalidate(mk(3, 9, 0));                   // R7 no-match
    access(1, 1, mk(2, 3, 0), 32'h0000_AAAA);
    access(0, 0, mk(1, 7, 0), '0);
    access(1, 1, mk(1, 7, 3), 32'h0000_BBBB);
    flush();                                   // R4
    access(0, 0, mk(1, 7, 3), '0);             // R4 line still valid after flush

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 100;
      logic [AW-1:0] a = mk($urandom % 4, $urandom % NL, $urandom % NW);
      if (n % 40 == 0) fill_inhibit = ($urandom % 4 == 0);
      if (r < 6)       invalidate(a);
      else if (r < 9)  flush();
      else if (r < 50) access(0, 0, a, '0);
      else             access(1, $urandom % 2, a, $urandom);
    end
    fill_inhibit = 1'b0;
    flush();

    summary();
    $finish;
  end

endmodule